// File: doc/BRIEF.md
# Descriptor-Driven Memory CRC Scanner

This block is a small read-only bus master that computes a CRC over a region of memory. Software places a job descriptor in memory, gives the block its base address and pulses a start input. The block then fetches the descriptor: the buffer start address, a control word, and an expected CRC. It reads the buffer one element at a time through a request/acknowledge port and feeds each element to a bit-serial CRC engine. It counts the elements down, and at the end it can compare the result against the expected value.

Each element read is a single transfer of byte, halfword or word size. A rate divider spaces the requests out so that the scan uses only a small share of the bus. Completion and mismatch are kept as sticky flags. Each flag drives an interrupt line through a mask with set and clear inputs.

Top module: `crc_scan_dma`

## Requirements
- R1: After a start, the block reads three descriptor words as word-size transfers (mem_size 2): first desc_base+0x00 (buffer address), then desc_base+0x04 (control word), then desc_base+0x10 (expected CRC), before any data read.
- R2: The control word supplies the element count in bits [15:0], the width in bits [25:24] (0 byte, 1 halfword, 2 word) and the completion interrupt enable in bit 27. Data read k goes to buffer address + k*(1, 2 or 4) with mem_size equal to the width code, and exactly count data reads are made.
- R3: Only one request is outstanding at a time. mem_req stays high with mem_addr and mem_size unchanged until the cycle in which mem_ack is seen.
- R4: Rising edges of mem_req are at least 2^(divider+1) clock cycles apart.
- R5: The CRC is processed LSB first on the low 8, 16 or 32 bits of mem_rdata. poly_sel, sampled at start, selects the polynomial: 0 gives reflected 0xEDB88320 with 32-bit init all ones; 1 gives reflected 0x82F63B78 with 32-bit init all ones; 2 gives reflected 0x8408 with 16-bit init 0xFFFF. There is no final inversion, and crc_out holds the result.
- R6: While mode_en is low, data reads still take place, but crc_out keeps its initial value.
- R7: A count of zero ends the job after the three descriptor reads, with no data reads, and sets the done flag.
- R8: busy rises the cycle after an accepted start and falls when the job completes. At that point flags[0] (done) is set. A start while busy has no effect.
- R9: With cmp_en high, a final CRC that differs from the expected word sets flags[1] (error); only the low 16 bits are compared for poly_sel 2. A match, or cmp_en low, leaves flags[1] clear.
- R10: int_set and int_clr set and clear bits of int_mask, with clear taking priority. flag_clr clears both flags. irq = (flags[0] & int_mask[0] & completion enable) | (flags[1] & int_mask[1]). All of these are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_start | input | 1 | Start pulse; accepted only while idle |
| mode_en | input | 1 | CRC engine enable |
| cmp_en | input | 1 | Compare final CRC with expected |
| poly_sel | input | 2 | Polynomial select |
| divider | input | DIV_W | Request rate divider |
| desc_base | input | AW | Descriptor base address |
| int_set | input | 2 | Mask bit set pulses |
| int_clr | input | 2 | Mask bit clear pulses |
| flag_clr | input | 1 | Clear both flags |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_size | output | 2 | Transfer size code |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Job in progress |
| crc_out | output | 32 | Current CRC value |
| flags | output | 2 | Bit 0 done, bit 1 error |
| int_mask | output | 2 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that mem_ack is high only in a cycle where mem_req is high. They also assume that divider, poly_sel, cmp_en and mode_en do not change while busy is high. The bench memory model acknowledges a pending request after a fixed latency and never acknowledges without one. The bench changes configuration inputs only while the block is idle, so the request spacing and hold properties are judged against a steady setting.

// File: rtl/crc_scan_dma.sv
module crc_scan_dma #(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_start,
  input  logic             mode_en,
  input  logic             cmp_en,
  input  logic [1:0]       poly_sel,
  input  logic [DIV_W-1:0] divider,
  input  logic [AW-1:0]    desc_base,
  input  logic [1:0]       int_set,
  input  logic [1:0]       int_clr,
  input  logic             flag_clr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic [31:0]      crc_out,
  output logic [1:0]       flags,
  output logic [1:0]       int_mask,
  output logic             irq
);
  localparam int SW = (1 << DIV_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_DADDR, S_DCTRL, S_DEXP, S_DATA, S_FIN} st_t;
  st_t st;

  logic [AW-1:0]    base_q, ptr_q, next_addr;
  logic [1:0]       wid_q, psel_q, wid_in;
  logic             ien_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      exp_q, poly_v;
  logic [SW-1:0]    since_q, period_m1;
  logic [5:0]       nbits;
  logic [1:0]       fin_set;

  function automatic logic [31:0] crc_unit(input logic [31:0] c0, input logic [31:0] d,
                                           input logic [5:0] nb, input logic [31:0] p);
    logic [31:0] c;
    logic fb;
    c = c0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(nb)) begin
        fb = c[0] ^ d[i];
        c  = c >> 1;
        if (fb) c = c ^ p;
      end
    end
    return c;
  endfunction

  assign busy      = (st != S_IDLE);
  assign period_m1 = (SW'(1) << (32'(divider) + 32'd1)) - SW'(1);
  assign poly_v    = (psel_q == 2'd0) ? 32'hEDB8_8320 :
                     (psel_q == 2'd1) ? 32'h82F6_3B78 : 32'h0000_8408;
  assign nbits     = (wid_q == 2'd0) ? 6'd8 : (wid_q == 2'd1) ? 6'd16 : 6'd32;
  assign wid_in    = (mem_rdata[25:24] == 2'd3) ? 2'd2 : mem_rdata[25:24];
  assign irq       = (flags[0] & int_mask[0] & ien_q) | (flags[1] & int_mask[1]);

  wire need_rd   = (st == S_DADDR) || (st == S_DCTRL) || (st == S_DEXP) || (st == S_DATA);
  wire can_issue = need_rd && !mem_req && (since_q >= period_m1);
  wire take      = mem_req && mem_ack;
  wire crc_ok    = (psel_q == 2'd2) ? (crc_out[15:0] == exp_q[15:0]) : (crc_out == exp_q);

  always_comb begin
    case (st)
      S_DADDR: next_addr = base_q;
      S_DCTRL: next_addr = base_q + AW'(4);
      S_DEXP:  next_addr = base_q + AW'(16);
      default: next_addr = ptr_q;
    endcase
  end

  assign fin_set = (st == S_FIN) ? {cmp_en & ~crc_ok, 1'b1} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      int_mask <= '0;
    end else begin
      flags    <= (flags & ~{2{flag_clr}}) | fin_set;
      int_mask <= (int_mask | int_set) & ~int_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q  <= '1;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_size <= '0;
    end else begin
      if (can_issue) begin
        since_q  <= '0;
        mem_req  <= 1'b1;
        mem_addr <= next_addr;
        mem_size <= (st == S_DATA) ? wid_q : 2'd2;
      end else begin
        if (since_q != '1) since_q <= since_q + SW'(1);
        if (take) mem_req <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      wid_q   <= '0;
      psel_q  <= '0;
      ien_q   <= 1'b0;
      cnt_q   <= '0;
      exp_q   <= '0;
      crc_out <= '0;
    end else begin
      case (st)
        S_IDLE: if (dma_start) begin
          st      <= S_DADDR;
          base_q  <= desc_base;
          psel_q  <= poly_sel;
          crc_out <= (poly_sel == 2'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        end
        S_DADDR: if (take) begin
          ptr_q <= mem_rdata[AW-1:0];
          st    <= S_DCTRL;
        end
        S_DCTRL: if (take) begin
          wid_q <= wid_in;
          ien_q <= mem_rdata[27];
          cnt_q <= mem_rdata[CNT_W-1:0];
          st    <= S_DEXP;
        end
        S_DEXP: if (take) begin
          exp_q <= mem_rdata;
          st    <= (cnt_q == '0) ? S_FIN : S_DATA;
        end
        S_DATA: if (take) begin
          if (mode_en) crc_out <= crc_unit(crc_out, mem_rdata, nbits, poly_v);
          ptr_q <= ptr_q + (AW'(1) << wid_q);
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc_scan_dma_chk.sv
module crc_scan_dma_chk #(
  parameter int AW    = 32,
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divider,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic [1:0]       mem_size,
  input logic             mem_ack,
  input logic             busy,
  input logic [1:0]       flags,
  input logic [1:0]       int_mask,
  input logic             irq
);
  localparam int SW = (1 << DIV_W) + 1;
  logic [SW-1:0] gap_q;
  logic          req_d;
  wire  [SW-1:0] need = (SW'(1) << (32'(divider) + 32'd1)) - SW'(1);
  wire           req_rise = mem_req && !req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '1;
      req_d <= 1'b0;
    end else begin
      req_d <= mem_req;
      if (req_rise) gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + SW'(1);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)); // R3
  AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |-> gap_q >= need); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> !busy); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(flags & int_mask)); // R10
endmodule

bind crc_scan_dma crc_scan_dma_chk #(.AW(AW), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divider(divider), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_size(mem_size), .mem_ack(mem_ack), .busy(busy), .flags(flags),
  .int_mask(int_mask), .irq(irq));

// File: tb/crc_scan_dma_tb.sv
module crc_scan_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic dma_start = 0, mode_en = 1, cmp_en = 0, flag_clr = 0;
  logic [1:0] poly_sel = 0, int_set = 0, int_clr = 0;
  logic [3:0] divider = 0;
  logic [31:0] desc_base = 0;
  logic mem_req, mem_ack = 0, busy, irq;
  logic [31:0] mem_addr, mem_rdata = 0, crc_out;
  logic [1:0] mem_size, flags, int_mask;

  crc_scan_dma dut_i (
    .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .mode_en(mode_en), .cmp_en(cmp_en),
    .poly_sel(poly_sel), .divider(divider), .desc_base(desc_base), .int_set(int_set),
    .int_clr(int_clr), .flag_clr(flag_clr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
    .crc_out(crc_out), .flags(flags), .int_mask(int_mask), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] d_base, d_buf, d_ctrl, d_exp;
  logic [31:0] log_addr [64];
  logic [1:0]  log_size [64];
  int n_req = 0, min_gap = 1000000, last_rise = -1, lat = 0, hold_bad = 0;
  logic prv = 0;

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a == d_base) return d_buf;
    if (a == d_base + 4) return d_ctrl;
    if (a == d_base + 16) return d_exp;
    return {byte_at(a + 3), byte_at(a + 2), byte_at(a + 1), byte_at(a)};
  endfunction

  always @(negedge clk) begin
    if (mem_req && !prv) begin
      if (n_req < 64) begin log_addr[n_req] = mem_addr; log_size[n_req] = mem_size; end
      if (last_rise >= 0 && cyc - last_rise < min_gap) min_gap = cyc - last_rise;
      last_rise = cyc;
      n_req++;
    end
    prv = mem_req;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (lat == LAT) begin
        if (n_req > 0 && n_req <= 64 && mem_addr !== log_addr[n_req-1]) hold_bad++;
        mem_rdata = mem_word(mem_addr);
        mem_ack = 1;
        lat = 0;
      end else lat++;
    end
  end

  function automatic logic [31:0] ref_crc(input int poly, input int wid, input int cnt,
                                          input logic [31:0] b, input bit mode);
    logic [31:0] c, p, d;
    logic fb;
    c = (poly == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (!mode) return c;
    p = (poly == 0) ? 32'hEDB88320 : (poly == 1) ? 32'h82F63B78 : 32'h8408;
    for (int k = 0; k < cnt; k++) begin
      d = mem_word(b + k * (1 << wid));
      for (int i = 0; i < (8 << wid); i++) begin
        fb = c[0] ^ d[i];
        c = c >> 1;
        if (fb) c = c ^ p;
      end
    end
    return c;
  endfunction

  task automatic launch(input logic [31:0] base, input logic [31:0] bufa, input int wid,
                        input bit ien, input int cnt, input logic [31:0] expv);
    d_base = base; d_buf = bufa; d_exp = expv;
    d_ctrl = (32'(wid) << 24) | (32'(ien) << 27) | 32'(cnt);
    n_req = 0; min_gap = 1000000; last_rise = -1; hold_bad = 0;
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    desc_base = base;
    dma_start = 1;
    @(negedge clk);
    dma_start = 0;
  endtask

  task automatic wait_idle(input string req);
    int w = 0;
    while (busy && w < 20000) begin @(negedge clk); w++; end
    chk(req, {31'b0, busy}, 32'd0);
  endtask

  localparam logic [17:0] VEC [6] = '{
    {2'd0, 2'd0, 8'd5, 3'd0, 1'b1, 1'b1, 1'b1},
    {2'd1, 2'd1, 8'd3, 3'd1, 1'b1, 1'b1, 1'b1},
    {2'd2, 2'd2, 8'd4, 3'd0, 1'b1, 1'b1, 1'b0},
    {2'd0, 2'd2, 8'd2, 3'd2, 1'b1, 1'b1, 1'b1},
    {2'd2, 2'd0, 8'd6, 3'd0, 1'b0, 1'b1, 1'b0},
    {2'd1, 2'd0, 8'd3, 3'd0, 1'b1, 1'b0, 1'b1}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state R8 R10
    chk("R8 busy at reset", {31'b0, busy}, 0);
    chk("R10 flags/mask/irq at reset", {27'b0, flags, int_mask, irq}, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      int poly, wid, cnt, dv;
      bit cm, md, good;
      logic [31:0] base, bufa, ref_v;
      poly = VEC[i][17:16]; wid = VEC[i][15:14]; cnt = VEC[i][13:6]; dv = VEC[i][5:3];
      cm = VEC[i][2]; md = VEC[i][1]; good = VEC[i][0];
      base = 32'h1000 + 32'(i) * 32'h40; bufa = 32'h200 + 32'(i) * 3;
      poly_sel = 2'(poly); divider = 4'(dv); cmp_en = cm; mode_en = md;
      d_base = base; d_buf = bufa;
      ref_v = ref_crc(poly, wid, cnt, bufa, md);
      launch(base, bufa, wid, 0, cnt, good ? ref_v : ref_v ^ 32'h1);
      wait_idle("R8 job finishes");
      chk("R5/R6 crc value", crc_out, ref_v);
      chk("R9 error flag", {31'b0, flags[1]}, {31'b0, cm & ~good});
      chk("R8 done flag", {31'b0, flags[0]}, 1);
      chk("R1 request count", n_req, 3 + cnt);
      chk("R1 descriptor order", {log_addr[0], log_addr[1] - base, log_addr[2] - base},
          {base, 32'h4, 32'h10});
      chk("R1 descriptor size", {log_size[0], log_size[1], log_size[2]}, 6'b101010);
      for (int k = 0; k < cnt; k++) begin
        chk("R2 data address", log_addr[3+k], bufa + 32'(k * (1 << wid)));
        chk("R2 data size", 32'(log_size[3+k]), 32'(wid));
      end
      chk("R4 request spacing", (min_gap >= (2 << dv)) ? 1 : 0, 1);
      chk("R3 address held", hold_bad, 0);
    end

    // R7 zero count
    poly_sel = 0; divider = 0; cmp_en = 0; mode_en = 1;
    launch(32'h2000, 32'h300, 0, 1, 0, 0);
    wait_idle("R7 finishes");
    chk("R7 only descriptor reads", n_req, 3);
    chk("R7 done flag", {31'b0, flags[0]}, 1);
    chk("R7 crc untouched", crc_out, 32'hFFFF_FFFF);

    // R10 interrupt mask and flags (ien=1, done set)
    @(negedge clk); int_set = 2'b01; @(negedge clk); int_set = 0;
    chk("R10 mask set", {30'b0, int_mask}, 1);
    chk("R10 irq done with ien", {31'b0, irq}, 1);
    int_set = 2'b11; int_clr = 2'b01; @(negedge clk); int_set = 0; int_clr = 0;
    chk("R10 clear wins", {30'b0, int_mask}, 2);
    chk("R10 irq masked", {31'b0, irq}, 0);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk("R10 flag clear", {30'b0, flags}, 0);

    // R9/R10 error interrupt, CRC16 low-half compare
    poly_sel = 2; cmp_en = 1;
    d_base = 32'h2100; d_buf = 32'h340;
    begin
      logic [31:0] r;
      r = ref_crc(2, 1, 2, 32'h340, 1);
      launch(32'h2100, 32'h340, 1, 0, 2, r | 32'hABCD_0000);
      wait_idle("R9 finishes");
      chk("R9 crc16 upper bits ignored", {31'b0, flags[1]}, 0);
      launch(32'h2100, 32'h340, 1, 0, 2, r ^ 32'h100);
      wait_idle("R9 finishes");
      chk("R9 crc16 mismatch", {31'b0, flags[1]}, 1);
      chk("R10 irq from error", {31'b0, irq}, 1);
    end

    // R8 start while busy ignored
    poly_sel = 0; cmp_en = 0; divider = 3;
    launch(32'h2200, 32'h380, 0, 0, 4, 0);
    repeat (5) @(negedge clk);
    desc_base = 32'h2400; dma_start = 1; @(negedge clk); dma_start = 0;
    wait_idle("R8 finishes");
    chk("R8 second start ignored", n_req, 7);
    chk("R8 descriptor kept", log_addr[6], 32'h383);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule